// File: doc/BRIEF.md
# RAM-Backed Pair-Sum Sequencer

This block keeps a running record of signed samples in a small memory and adds two of them when asked. The memory has one write port and one read port. Whenever the input-valid strobe is high on a rising edge, the sample on the input bus is written at the current write pointer. The pointer then moves to the next location and wraps around at the end of the memory.

A start pulse seen in the idle state launches a fixed sequence. The sequencer drives the address of the first operand (location 0) onto the read port. It waits one cycle for the registered read data and captures it. It then does the same for the second operand (location 1), adds the two with one extra bit of headroom, and raises `done` for one cycle. The sum output keeps its value until the next command completes.

The states, in order, are: `SEQ_IDLE` (waiting for start), `SEQ_RD_A` (first address on the read port), `SEQ_WAIT_A` (first operand on the read data, captured), `SEQ_RD_B` (second address on the read port), `SEQ_WAIT_B` (second operand captured), `SEQ_ADD` (sum registered), and `SEQ_DONE` (done high). The transitions are:

- `SEQ_IDLE` goes to `SEQ_RD_A` when start is high.
- Each later state moves unconditionally to the next one.
- `SEQ_DONE` returns to `SEQ_IDLE`.

Top module: `pair_sum_engine`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in `SEQ_IDLE` and clears `done` and `sum_out` to 0 on the next edge. It leaves the memory contents unchanged and returns the write pointer to location 0.
- R2: On every rising edge with `in_valid` high, `in_sample` is stored at the write pointer. The pointer starts at 0 after reset, advances by one per write, and wraps modulo 2^ADDR_W, so write number n since reset lands at location n mod 2^ADDR_W.
- R3: A start seen in `SEQ_IDLE` on edge E0 makes `done` high in the cycle after edge E0+5 and low again after edge E0+6. `done` is never high for two cycles in a row.
- R4: With `done` high, `sum_out` (SAMPLE_W+1 bits, two's complement) equals the sign-extended content of location 0 plus the sign-extended content of location 1. This holds with no overflow across the full signed sample range, including -256 and +254 at 8-bit samples.
- R5: `sum_out` changes only on the edge that leaves `SEQ_ADD`, and otherwise holds its value.
- R6: A start that arrives in any state other than `SEQ_IDLE`, including `SEQ_DONE`, has no effect. Such a start produces no extra `done` pulse and does not change `sum_out`.
- R7: The read port is registered. A write to an operand's location on the same edge that registers that operand's read returns the old data for that command. Later commands see the new data.
- R8: The state order is `SEQ_IDLE`, `SEQ_RD_A`, `SEQ_WAIT_A`, `SEQ_RD_B`, `SEQ_WAIT_B`, `SEQ_ADD`, `SEQ_DONE`, `SEQ_IDLE`, with one cycle in each state after `SEQ_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write strobe for the input sample |
| in_sample | input | SAMPLE_W | Signed sample to store |
| start | input | 1 | Command pulse that launches an addition |
| done | output | 1 | One-cycle completion pulse |
| sum_out | output | SAMPLE_W+1 | Signed sum of locations 0 and 1, held between commands |

## Verification
A wrong write pointer shows up as a wrong sum at the very next `done`. The sweep fills the memory through a full wrap before every command, so a pointer that skips, sticks or fails to wrap corrupts the operands within one command. A sequencer that skips or repeats a state moves `done` off its sixth-edge slot or adds a second pulse, which the per-cycle checks catch within seven cycles. A register that captures the read data one cycle early or late takes the wrong location or stale data. The collision test and the full-range operand sweep expose this as a sum mismatch in the same command.

// File: rtl/pse_pkg.sv
package pse_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_RD_A   = 3'd1,
        SEQ_WAIT_A = 3'd2,
        SEQ_RD_B   = 3'd3,
        SEQ_WAIT_B = 3'd4,
        SEQ_ADD    = 3'd5,
        SEQ_DONE   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/pse_sample_ram.sv
// Simple dual-port storage: one write port, one registered read port.
module pse_sample_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic signed [DATA_W-1:0] cells [DEPTH];

    // Nonblocking update: a read of the location being written sees old data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
        rd_data <= cells[rd_addr];
    end

endmodule

// File: rtl/pse_wr_ptr.sv
// Write pointer: advances once per accepted write, wraps at the depth.
module pse_wr_ptr #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr + STEP;
        end
    end

endmodule

// File: rtl/pse_sequencer.sv
// Command sequencer: two fetches through one read port, then an add.
module pse_sequencer
    import pse_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int OPA_ADDR = 0,
    parameter int OPB_ADDR = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic signed [DATA_W:0]   sum,
    output logic                     done,
    output seq_state_e               state
);

    localparam int SUM_W = DATA_W + 1;
    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(OPA_ADDR);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(OPB_ADDR);

    seq_state_e state_nxt;
    logic signed [DATA_W-1:0] op_a;
    logic signed [DATA_W-1:0] op_b;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_IDLE:   state_nxt = start ? SEQ_RD_A : SEQ_IDLE;
            SEQ_RD_A:   state_nxt = SEQ_WAIT_A;
            SEQ_WAIT_A: state_nxt = SEQ_RD_B;
            SEQ_RD_B:   state_nxt = SEQ_WAIT_B;
            SEQ_WAIT_B: state_nxt = SEQ_ADD;
            SEQ_ADD:    state_nxt = SEQ_DONE;
            SEQ_DONE:   state_nxt = SEQ_IDLE;
            default:    state_nxt = SEQ_IDLE;
        endcase
    end

    // Read address follows the fetch phase: second operand only in RD_B.
    always_comb begin
        rd_addr = (state == SEQ_RD_B) ? ADDR_B : ADDR_A;
    end

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
            sum  <= '0;
            done <= 1'b0;
        end else begin
            done <= (state_nxt == SEQ_DONE);
            unique case (state)
                SEQ_WAIT_A: op_a <= rd_data;
                SEQ_WAIT_B: op_b <= rd_data;
                SEQ_ADD:    sum  <= SUM_W'(op_a) + SUM_W'(op_b);
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/pair_sum_engine.sv
module pair_sum_engine
    import pse_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ADDR_W   = 3,
    parameter int OPA_ADDR = 0,
    parameter int OPB_ADDR = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic                       start,
    output logic                       done,
    output logic signed [SAMPLE_W:0]   sum_out
);

    logic [ADDR_W-1:0]          wr_addr;
    logic [ADDR_W-1:0]          rd_addr;
    logic signed [SAMPLE_W-1:0] rd_data;
    seq_state_e                 seq_state;

    pse_wr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (in_valid),
        .ptr (wr_addr)
    );

    pse_sample_ram #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_en   (in_valid),
        .wr_addr (wr_addr),
        .wr_data (in_sample),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pse_sequencer #(
        .DATA_W   (SAMPLE_W),
        .ADDR_W   (ADDR_W),
        .OPA_ADDR (OPA_ADDR),
        .OPB_ADDR (OPB_ADDR)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .sum     (sum_out),
        .done    (done),
        .state   (seq_state)
    );

endmodule

// File: rtl/pse_checker.sv
module pse_checker
    import pse_pkg::*;
#(
    parameter int SUM_W = 9
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    done,
    input logic signed [SUM_W-1:0] sum_out,
    input seq_state_e              state
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && sum_out == '0 && state == SEQ_IDLE));

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && start) |=> (state == SEQ_RD_A));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state) == SEQ_ADD && state == SEQ_DONE));

    // R8
    order_a_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RD_A) |=> (state == SEQ_WAIT_A));

    // R8
    order_b_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_WAIT_A) |=> (state == SEQ_RD_B));

    // R8
    order_c_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_WAIT_B) |=> (state == SEQ_ADD));

    // R8
    order_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_DONE) |=> (state == SEQ_IDLE));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE) |=> (state != SEQ_RD_A));

    // R5
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_ADD) |=> $stable(sum_out));

endmodule

bind pair_sum_engine pse_checker #(.SUM_W(SAMPLE_W + 1)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .sum_out (sum_out),
    .state   (seq_state)
);

// File: tb/test_pair_sum_engine.sv
module test_pair_sum_engine;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 start = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic                 done;
    logic signed [DW:0]   sum_out;

    int n_cmp = 0;
    int n_bad = 0;
    int model [DEPTH];
    int ptr = 0;

    always #10 clk = ~clk;

    pair_sum_engine #(.SAMPLE_W(DW), .ADDR_W(AW)) i_pair_sum_engine (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .start     (start),
        .done      (done),
        .sum_out   (sum_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sum_now();
        return int'(sum_out);
    endfunction

    // R2: one write per call, model pointer wraps modulo DEPTH
    task automatic push(input int v);
        in_valid  = 1'b1;
        in_sample = DW'(v);
        @(negedge clk);
        in_valid  = 1'b0;
        model[ptr] = v;
        ptr = (ptr + 1) % DEPTH;
    endtask

    // Issues one command from a negedge and follows it cycle by cycle.
    task automatic run_cmd(input string req, input int exp, input bit poke,
                           input bit collide, input int cval, input int tail);
        start = 1'b1;
        @(negedge clk);               // edge E0 sampled start
        start = 1'b0;
        chk({req, " R3 R8 done low after E0"}, int'(done), 0);
        for (int k = 1; k <= 4; k++) begin
            if (poke && (k == 2 || k == 4)) start = 1'b1;
            if (collide && k == 1) begin
                in_valid  = 1'b1;
                in_sample = DW'(cval);
            end
            @(negedge clk);
            start    = 1'b0;
            in_valid = 1'b0;
            chk({req, " R3 R8 done low mid-command"}, int'(done), 0);
        end
        if (poke) start = 1'b1;       // arrives while in DONE
        @(negedge clk);               // after E0+5
        chk({req, " R3 done high"}, int'(done), 1);
        chk({req, " R4 sum"}, sum_now(), exp);
        @(negedge clk);               // after E0+6
        start = 1'b0;
        chk({req, " R3 done back low"}, int'(done), 0);
        chk({req, " R5 sum held"}, sum_now(), exp);
        for (int t = 0; t < tail; t++) begin
            @(negedge clk);
            chk({req, " R6 no extra done"}, int'(done), 0);
            chk({req, " R5 R6 sum unchanged"}, sum_now(), exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int exp_sum;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset sum", sum_now(), 0);
        rst = 1'b0;
        ptr = 0;

        // R2: ten writes wrap the pointer; locations 0 and 1 hold writes 8 and 9
        for (int i = 0; i < 10; i++) push(i * 11 - 40);
        run_cmd("R2 wrap", 48 + 59, 1'b0, 1'b0, 0, 1);

        // R6: starts during WAIT_A, WAIT_B and DONE are ignored
        run_cmd("R6 busy", 48 + 59, 1'b1, 1'b0, 0, 7);

        // R7: write to location 0 on the edge that registers its read
        while (ptr != 0) push(5);
        push(-50);
        push(30);
        while (ptr != 0) push(7);
        run_cmd("R7 collide", -50 + 30, 1'b0, 1'b1, 99, 1);
        model[0] = 99;
        ptr = 1;
        run_cmd("R7 new data", 99 + 30, 1'b0, 1'b0, 0, 1);

        // R1: reset clears outputs, keeps memory, resets the pointer
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset done", int'(done), 0);
        chk("R1 mid reset sum", sum_now(), 0);
        ptr = 0;
        run_cmd("R1 memory kept", model[0] + model[1], 1'b0, 1'b0, 0, 1);
        push(-3);                     // lands at location 0 after reset
        run_cmd("R1 R2 pointer reset", -3 + model[1], 1'b0, 1'b0, 0, 1);

        // R1: reset in the middle of a command cancels it
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ptr = 0;
        for (int t = 0; t < 7; t++) begin
            @(negedge clk);
            chk("R1 aborted command done", int'(done), 0);
            chk("R1 aborted command sum", sum_now(), 0);
        end

        // R4: full-range sweep of the first operand, stepped second operand
        for (int a = -128; a <= 127; a++) begin
            for (int b = -128; b <= 127; b += 17) begin
                while (ptr != 0) push((a + b) % 100);
                push(a);
                push(b);
                exp_sum = a + b;
                run_cmd("R4 sweep", exp_sum, 1'b0, 1'b0, 0, 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule